// File: doc/BRIEF.md
# Audio Frame Sequencer with Length and Envelope Control

This block produces the slow control rhythm of a four-channel sound generator and applies it to the length timer and the volume envelope of each channel. A prescaler divides the system clock down to a sequencer step. An eight-step pattern then emits three kinds of one-cycle strobes: a length strobe, a sweep strobe and an envelope strobe. The sweep strobe is only passed out, for a separate frequency-sweep unit.

Software writes channel settings through a single write port. Each write carries a channel index, a field kind and an 8-bit value. The block keeps a length counter, a length gate, a length enable, a DAC-on flag and an envelope state for every channel. From these it reports a running flag and a 4-bit volume per channel. A global sound-enable input clears everything while it is low.

Top module: `sound_frame_seq`

## Requirements
- R1: While `snd_en` is high, `step_idx` advances by one (modulo 8) every `STEP_DIV` clock cycles. After reset, or after `snd_en` rises, the first advance comes `STEP_DIV` cycles later.
- R2: Strobes are one-cycle pulses. They are high in the cycle in which `step_idx` leaves step s. `len_tick` fires for even s. `sweep_tick` fires for s = 2 and s = 6. `env_tick` fires for s = 7. Odd steps other than 7 give no strobe.
- R3: On `len_tick`, a channel whose length is enabled and whose gate is set increments its length counter. The counter is 8 bits wide for channel 2 (`WIDE_CH`) and 6 bits wide for the other channels. With length disabled the channel keeps running.
- R4: When a length counter wraps to zero, that channel clears its running flag, volume, envelope period and length gate.
- R5: A length write (`wr_kind` = 0) loads the counter from `wr_data`, masked to the channel's width, and sets the gate.
- R6: A control write (`wr_kind` = 2, bit 6 = length enable, bit 7 = trigger) that changes length enable from 0 to 1 clocks the counter once at once, but only when `step_idx[0]` is 1.
- R7: A trigger on a channel whose gate is clear sets the gate. If length enable was 1 before the write and stays 1, and `step_idx[0]` is 1, the counter is also clocked once.
- R8: An envelope write (`wr_kind` = 1) loads the volume from bits 7:4, the direction from bit 3 (1 = up) and the period from bits 2:0. If bits 7:3 are all zero, the DAC turns off and the channel stops.
- R9: On `env_tick`, a channel with a nonzero period counts down. When its count expires, the count reloads from the period and the volume moves one step in the chosen direction, saturating at 0 and 15. The volume changes only while the channel is running.
- R10: A trigger sets the running flag only when the DAC is on. The running flag never rises without a write to that channel.
- R11: While `snd_en` is low, from the next cycle on, all channel state and `step_idx` are zero, no strobe fires, and writes are ignored.
- R12: After reset, all running flags, volumes, strobes and `step_idx` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_en | input | 1 | Global sound enable; low clears and holds all state |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_ch | input | $clog2(NCH) | Channel index of the write |
| wr_kind | input | 2 | 0 length, 1 envelope, 2 control, 3 no effect |
| wr_data | input | 8 | Written value |
| running | output | NCH | Per-channel running flag |
| volume | output | 4*NCH | Per-channel 4-bit volume; channel i in bits 4i+3:4i |
| step_idx | output | 3 | Index of the next sequencer step |
| len_tick | output | 1 | Length strobe |
| sweep_tick | output | 1 | Sweep strobe for the sweep unit |
| env_tick | output | 1 | Envelope strobe |

## Verification
The assertions check, on every cycle, the properties that hold in any state. They cover the step index advancing by exactly one, the strobe pulses being single-cycle and mutually consistent, and a strobe-driven wrap silencing its channel. They also check that the running flag rises only after a write to that channel, that volume never rises without a write or an envelope strobe, and that sound-off clears everything. Some effects depend on specific values and ordering, so only the bench scenarios can show them. These include the exact strobe pattern and the step period, how many strobes each counter width needs to wrap, the extra clock on enable or trigger for odd versus even step parity, and the envelope period, direction and saturation.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  typedef enum logic [1:0] {
    WK_LEN  = 2'd0,
    WK_ENV  = 2'd1,
    WK_CTL  = 2'd2,
    WK_NONE = 2'd3
  } wr_kind_t;

  typedef struct packed {
    logic len;
    logic sweep;
    logic env;
  } seq_strobe_t;

  typedef struct packed {
    logic [7:0] cnt;
    logic       gate;
    logic       len_en;
    logic       run;
    logic       dac;
    logic       dir;
    logic [3:0] vol;
    logic [2:0] per;
    logic [2:0] ecnt;
  } ch_state_t;

  // Strobes issued when the sequencer leaves step s.
  function automatic seq_strobe_t step_strobes(input logic [2:0] s);
    seq_strobe_t r;
    r.len   = ~s[0];
    r.sweep = (s[1:0] == 2'b10);
    r.env   = (s == 3'd7);
    return r;
  endfunction

  function automatic logic length_wraps(input ch_state_t s, input logic [7:0] mask);
    return s.len_en && s.gate && (((s.cnt + 8'd1) & mask) == 8'd0);
  endfunction

  function automatic ch_state_t clock_length(input ch_state_t s, input logic [7:0] mask);
    ch_state_t r;
    r = s;
    if (s.len_en && s.gate) begin
      r.cnt = (s.cnt + 8'd1) & mask;
      if (r.cnt == 8'd0) begin
        r.run  = 1'b0;
        r.vol  = 4'd0;
        r.per  = 3'd0;
        r.gate = 1'b0;
      end
    end
    return r;
  endfunction

  function automatic logic [3:0] vol_step(input logic [3:0] v, input logic up);
    logic [3:0] r;
    r = v;
    if (up && v != 4'd15) r = v + 4'd1;
    else if (!up && v != 4'd0) r = v - 4'd1;
    return r;
  endfunction

  function automatic ch_state_t clock_envelope(input ch_state_t s);
    ch_state_t r;
    r = s;
    if (s.per != 3'd0) begin
      if (s.ecnt <= 3'd1) begin
        r.ecnt = s.per;
        if (s.run) r.vol = vol_step(s.vol, s.dir);
      end else begin
        r.ecnt = s.ecnt - 3'd1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/sfs_divider.sv
module sfs_divider
  import sfs_pkg::*;
#(
  parameter int unsigned STEP_DIV = 8192
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  output logic [2:0]  step_q,
  output seq_strobe_t strobe_q
);
  localparam int unsigned CNT_W = (STEP_DIV > 2) ? $clog2(STEP_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      cnt_q    <= '0;
      step_q   <= 3'd0;
      strobe_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q    <= '0;
      step_q   <= step_q + 3'd1;
      strobe_q <= step_strobes(step_q);
    end else begin
      cnt_q    <= cnt_q + 1'b1;
      strobe_q <= '0;
    end
  end
endmodule

// File: rtl/sfs_channel.sv
module sfs_channel
  import sfs_pkg::*;
#(
  parameter logic [7:0] LEN_MASK = 8'h3F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       len_stb,
  input  logic       env_stb,
  input  logic       step_lsb,
  input  logic       wr_len,
  input  logic       wr_env,
  input  logic       wr_ctl,
  input  logic [7:0] wr_data,
  output logic       running,
  output logic [3:0] volume,
  output logic       len_wrap
);
  ch_state_t q, n;
  logic      wrap;
  logic      old_en;

  always_comb begin
    n      = q;
    wrap   = 1'b0;
    old_en = q.len_en;
    if (len_stb) begin
      wrap = length_wraps(n, LEN_MASK);
      n    = clock_length(n, LEN_MASK);
    end
    if (env_stb) n = clock_envelope(n);
    if (wr_len) begin
      n.cnt  = wr_data & LEN_MASK;
      n.gate = 1'b1;
    end
    if (wr_env) begin
      n.vol  = wr_data[7:4];
      n.dir  = wr_data[3];
      n.per  = wr_data[2:0];
      n.ecnt = wr_data[2:0];
      n.dac  = |wr_data[7:3];
      if (!n.dac) n.run = 1'b0;
    end
    if (wr_ctl) begin
      old_en   = n.len_en;
      n.len_en = wr_data[6];
      if (wr_data[7]) begin
        if (!n.gate) begin
          n.gate = 1'b1;
          if (old_en && n.len_en && step_lsb) begin
            wrap = wrap | length_wraps(n, LEN_MASK);
            n    = clock_length(n, LEN_MASK);
          end
        end
        if (n.dac) n.run = 1'b1;
      end
      if (!old_en && n.len_en && step_lsb) begin
        wrap = wrap | length_wraps(n, LEN_MASK);
        n    = clock_length(n, LEN_MASK);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) q <= '0;
    else                   q <= n;
  end

  assign running  = q.run;
  assign volume   = q.vol;
  assign len_wrap = wrap;
endmodule

// File: rtl/sound_frame_seq.sv
module sound_frame_seq
  import sfs_pkg::*;
#(
  parameter int unsigned STEP_DIV = 8192,
  parameter int unsigned NCH      = 4,
  parameter int unsigned WIDE_CH  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   snd_en,
  input  logic                   wr_en,
  input  logic [$clog2(NCH)-1:0] wr_ch,
  input  logic [1:0]             wr_kind,
  input  logic [7:0]             wr_data,
  output logic [NCH-1:0]         running,
  output logic [NCH*4-1:0]       volume,
  output logic [2:0]             step_idx,
  output logic                   len_tick,
  output logic                   sweep_tick,
  output logic                   env_tick
);
  localparam int unsigned CH_W = $clog2(NCH);

  seq_strobe_t     stb;
  logic [NCH-1:0]  ch_write;
  logic [NCH-1:0]  len_wrap;

  sfs_divider #(.STEP_DIV(STEP_DIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (snd_en),
    .step_q   (step_idx),
    .strobe_q (stb)
  );

  assign len_tick   = stb.len;
  assign sweep_tick = stb.sweep;
  assign env_tick   = stb.env;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;
    assign sel         = wr_en && (wr_ch == CH_W'(i));
    assign ch_write[i] = sel && (wr_kind != WK_NONE);

    sfs_channel #(.LEN_MASK((i == WIDE_CH) ? 8'hFF : 8'h3F)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (snd_en),
      .len_stb  (stb.len),
      .env_stb  (stb.env),
      .step_lsb (step_idx[0]),
      .wr_len   (sel && wr_kind == WK_LEN),
      .wr_env   (sel && wr_kind == WK_ENV),
      .wr_ctl   (sel && wr_kind == WK_CTL),
      .wr_data  (wr_data),
      .running  (running[i]),
      .volume   (volume[i*4 +: 4]),
      .len_wrap (len_wrap[i])
    );
  end
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
  parameter int unsigned NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           snd_en,
  input logic [NCH-1:0] running,
  input logic [NCH*4-1:0] volume,
  input logic [2:0]     step_idx,
  input logic           len_tick,
  input logic           sweep_tick,
  input logic           env_tick,
  input logic [NCH-1:0] ch_write,
  input logic [NCH-1:0] len_wrap
);
  assert_step_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_en && $past(snd_en) && !$stable(step_idx)) |-> (step_idx == $past(step_idx) + 3'd1));

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({len_tick, env_tick}) && (!sweep_tick || len_tick));

  assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (len_tick || env_tick) |=> (!len_tick && !env_tick));

  assert_sound_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !snd_en |=> (running == '0 && volume == '0 && step_idx == 3'd0 && !len_tick && !env_tick));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_wrap_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (len_wrap[i] && !ch_write[i]) |=> (!running[i] && volume[i*4 +: 4] == 4'd0));

    assert_run_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running[i]) |-> $past(ch_write[i]));

    assert_vol_no_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!env_tick && !ch_write[i]) |=> (volume[i*4 +: 4] <= $past(volume[i*4 +: 4])));
  end
endmodule

bind sound_frame_seq sfs_checker #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .snd_en     (snd_en),
  .running    (running),
  .volume     (volume),
  .step_idx   (step_idx),
  .len_tick   (len_tick),
  .sweep_tick (sweep_tick),
  .env_tick   (env_tick),
  .ch_write   (ch_write),
  .len_wrap   (len_wrap)
);

// File: tb/sound_frame_seq_test.sv
module sound_frame_seq_test;
  localparam int DIV = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        snd_en = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_ch = 2'd0;
  logic [1:0]  wr_kind = 2'd3;
  logic [7:0]  wr_data = 8'd0;
  logic [3:0]  running;
  logic [15:0] volume;
  logic [2:0]  step_idx;
  logic        len_tick, sweep_tick, env_tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sound_frame_seq #(.STEP_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .snd_en(snd_en),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_kind(wr_kind), .wr_data(wr_data),
    .running(running), .volume(volume), .step_idx(step_idx),
    .len_tick(len_tick), .sweep_tick(sweep_tick), .env_tick(env_tick)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int vol(input int ch);
    return int'(volume[ch*4 +: 4]);
  endfunction

  task automatic wr(input int ch, input int kind, input int data);
    wr_en = 1'b1; wr_ch = ch[1:0]; wr_kind = kind[1:0]; wr_data = data[7:0];
    @(negedge clk);
    wr_en = 1'b0; wr_kind = 2'd3;
  endtask

  // Move to a quiet cycle just after step_idx has entered a step of the given parity.
  task automatic sync_step(input int parity);
    forever begin
      int prev;
      prev = int'(step_idx);
      @(negedge clk);
      if (int'(step_idx) != prev && int'(step_idx[0]) == parity) break;
    end
    @(negedge clk);
  endtask

  task automatic wait_len;
    do @(negedge clk); while (!len_tick);
    @(negedge clk);
  endtask

  task automatic wait_env;
    do @(negedge clk); while (!env_tick);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R12 running", int'(running), 0);
    check("R12 volume", int'(volume), 0);
    check("R12 step", int'(step_idx), 0);
    check("R12 strobes", int'({len_tick, sweep_tick, env_tick}), 0);
  endtask

  task automatic t_pattern;
    int prev, stray;
    stray = 0;
    prev = int'(step_idx);
    do @(negedge clk); while (int'(step_idx) == prev);
    for (int k = 0; k < 16; k++) begin
      int cyc;
      cyc = 0;
      prev = int'(step_idx);
      do begin
        @(negedge clk);
        cyc++;
        if (int'(step_idx) == prev && (len_tick || sweep_tick || env_tick)) stray++;
      end while (int'(step_idx) == prev);
      check("R1 period", cyc, DIV);
      check("R1 next step", int'(step_idx), (prev + 1) % 8);
      check("R2 len strobe", int'(len_tick), (prev % 2 == 0) ? 1 : 0);
      check("R2 sweep strobe", int'(sweep_tick), (prev == 2 || prev == 6) ? 1 : 0);
      check("R2 env strobe", int'(env_tick), (prev == 7) ? 1 : 0);
    end
    check("R2 no stray strobes", stray, 0);
  endtask

  task automatic t_wrap;
    sync_step(0);
    wr(0, 1, 'hF0);
    wr(0, 0, 'h3E);
    wr(0, 2, 'hC0);
    check("R5 running after trigger", int'(running[0]), 1);
    check("R8 volume loaded", vol(0), 15);
    wait_len;
    check("R3 running after one clock", int'(running[0]), 1);
    wait_len;
    check("R4 stopped on wrap", int'(running[0]), 0);
    check("R4 volume cleared", vol(0), 0);
    sync_step(0);
    wr(0, 2, 'hC0);
    check("R7 retrigger runs", int'(running[0]), 1);
    check("R4 volume stays cleared", vol(0), 0);
    for (int k = 0; k < 63; k++) wait_len;
    check("R7 gate set, 63 clocks", int'(running[0]), 1);
    wait_len;
    check("R7 gate set, 64 clocks wrap", int'(running[0]), 0);
  endtask

  task automatic t_wide;
    sync_step(0);
    wr(1, 1, 'hF0); wr(1, 0, 'hBF); wr(1, 2, 'hC0);
    wr(2, 1, 'hF0); wr(2, 0, 'hBF); wr(2, 2, 'hC0);
    wr(3, 1, 'hF0); wr(3, 0, 'h3F); wr(3, 2, 'h80);
    wait_len;
    check("R3 narrow counter wrapped", int'(running[1]), 0);
    check("R3 wide counter running", int'(running[2]), 1);
    for (int k = 1; k < 64; k++) wait_len;
    check("R3 wide after 64", int'(running[2]), 1);
    wait_len;
    check("R3 wide wraps at 65", int'(running[2]), 0);
    check("R3 length disabled keeps running", int'(running[3]), 1);
  endtask

  task automatic t_enable_clock;
    sync_step(1);
    wr(3, 2, 'h40);
    check("R6 odd enable clocks", int'(running[3]), 0);
    sync_step(0);
    wr(1, 1, 'hF0); wr(1, 0, 'h3F); wr(1, 2, 'h80); wr(1, 2, 'h40);
    check("R6 even enable no clock", int'(running[1]), 1);
  endtask

  task automatic t_trigger_clock;
    int n;
    sync_step(1);
    wr(0, 2, 'hC0);
    check("R7 odd trigger runs", int'(running[0]), 1);
    n = 0;
    while (running[0] && n < 80) begin
      wait_len;
      n++;
    end
    check("R7 extra clock leaves 63", n, 63);
    sync_step(0);
    wr(0, 2, 'h80);
    wr(0, 1, 'h07);
    check("R8 dac off stops", int'(running[0]), 0);
    wr(0, 2, 'h80);
    check("R10 trigger with dac off", int'(running[0]), 0);
  endtask

  task automatic t_envelope;
    sync_step(0);
    wr(1, 1, 'hA2); wr(1, 2, 'h80);
    wr(2, 1, 'hE9); wr(2, 2, 'h80);
    wr(3, 1, 'h11); wr(3, 2, 'h80);
    wr(0, 1, 'hF1);
    check("R9 initial volume", vol(1), 10);
    wait_env;
    check("R9 period 2 first tick", vol(1), 10);
    check("R9 up step", vol(2), 15);
    check("R9 down step", vol(3), 0);
    check("R9 not running frozen", vol(0), 15);
    wait_env;
    check("R9 period 2 second tick", vol(1), 9);
    check("R9 saturate high", vol(2), 15);
    check("R9 saturate low", vol(3), 0);
    wait_env;
    wait_env;
    check("R9 period 2 fourth tick", vol(1), 8);
  endtask

  task automatic t_sound_off;
    int stray, cyc;
    stray = 0;
    snd_en = 1'b0;
    @(negedge clk);
    check("R11 running cleared", int'(running), 0);
    check("R11 volume cleared", int'(volume), 0);
    check("R11 step cleared", int'(step_idx), 0);
    wr(0, 1, 'hF0);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (len_tick || sweep_tick || env_tick || step_idx != 3'd0) stray++;
    end
    check("R11 no strobes while off", stray, 0);
    snd_en = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (step_idx == 3'd0 && cyc < 100);
    check("R1 first step after enable", cyc, DIV);
    check("R11 write while off ignored", vol(0), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_pattern;
    t_wrap;
    t_wide;
    t_enable_clock;
    t_trigger_clock;
    t_envelope;
    t_sound_off;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule